// File: doc/BRIEF.md
# Flash Erase Command Sequence Decoder

This block sits on the bus-write side of a flash device and watches every write cycle. It recognises the two six-write erase commands: a first unlock pair, a set-up code, a second unlock pair, and a final code. The final code picks either a whole-device erase or an erase of one 128 KB sector. When a sequence completes, the block sends a one-cycle request to the erase engine. The request carries the erase type and, for a sector erase, the sector number.

The write strobe arrives asynchronously and is synchronised to the internal clock. Edge detection on the synchronised strobe gives two sampling points. The address is captured at the falling edge and the data at the rising edge. A completed write is decoded once its rising edge has been seen. A write that does not fit the expected step returns the decoder to idle, and that write does not begin a new sequence. While the erase engine reports busy, the decoder stays idle, so no request can be raised. The device needs no pre-programming before an erase, so no such step is checked.

Top module: `erase_cmd_decoder`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), erase_req, erase_chip and erase_sector are 0, and a partially entered sequence is discarded.
- R2: The writes AAH@00555H, 55H@002AAH, 80H@00555H, AAH@00555H, 55H@002AAH, 10H@00555H produce exactly one erase_req pulse with erase_chip = 1. An unlock or code write matches on bus_addr[16:0] only; bits 20:17 are ignored.
- R3: The same five leading writes followed by 30H at any address produce exactly one erase_req pulse with erase_chip = 0 and erase_sector = bus_addr[20:17] of that final write. Sector n spans byte addresses n*20000H to n*20000H+1FFFFH.
- R4: The address of each write is the value on bus_addr when the falling edge of we_n is detected. A later change while we_n is low has no effect.
- R5: The data of each write is the value on bus_data when the rising edge of we_n is detected.
- R6: erase_req is high for exactly one clock cycle. It is raised only after the rising edge of the sixth write, never after the first five.
- R7: A write that does not match the expected step returns the decoder to idle. The remaining writes of the interrupted sequence then produce no request, and a fresh full sequence is accepted afterwards.
- R8: A sixth write carrying a code other than 10H or 30H, or 10H at an address other than 00555H, produces no request.
- R9: While engine_busy is 1, the decoder is held idle. A sequence entered fully or partly while busy produces no request, and erase_req is never high in the cycle after engine_busy was high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Synchronous active-low reset |
| we_n | input | 1 | Asynchronous active-low bus write strobe |
| bus_addr | input | 21 | Byte address of the bus write |
| bus_data | input | 8 | Data byte of the bus write |
| engine_busy | input | 1 | Erase engine is running; holds the decoder idle |
| erase_req | output | 1 | One-cycle erase request |
| erase_chip | output | 1 | Erase type with the request: 1 whole device, 0 one sector |
| erase_sector | output | 4 | Sector number with a sector request |

## Verification
The assertions check on every cycle that a request lasts one cycle and always follows a captured write. They also check that it never follows a busy cycle, and that its type and sector agree with the final write's code and address. In the capture stage they check that the latched address is the bus value at the falling edge and that the data is the bus value at the rising edge. Only the bench scenarios can show that a whole sequence is recognised in order. The same applies to a broken or mistyped sequence leaving no request, to an address changed mid-pulse being ignored, and to a reset or busy period discarding a partial sequence.

// File: rtl/erase_cmd_pkg.sv
// Shared constants and types for the erase command decoder.
// Assumes byte addressing: bit 0 of the address is the byte select.
package erase_cmd_pkg;
    localparam int ADDR_W     = 21;
    localparam int DATA_W     = 8;
    localparam int SECTOR_W   = 4;
    localparam int OFFSET_W   = ADDR_W - SECTOR_W;

    localparam logic [OFFSET_W-1:0] UNLOCK_A_ADDR = OFFSET_W'('h555);
    localparam logic [OFFSET_W-1:0] UNLOCK_B_ADDR = OFFSET_W'('h2AA);
    localparam logic [DATA_W-1:0]   UNLOCK_A_DATA = 8'hAA;
    localparam logic [DATA_W-1:0]   UNLOCK_B_DATA = 8'h55;
    localparam logic [DATA_W-1:0]   SETUP_CODE    = 8'h80;
    localparam logic [DATA_W-1:0]   CHIP_CODE     = 8'h10;
    localparam logic [DATA_W-1:0]   SECTOR_CODE   = 8'h30;

    // Progress through the six-write sequence; each name is the last accepted step.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_UNLOCK1,
        ST_UNLOCK2,
        ST_SETUP,
        ST_UNLOCK3,
        ST_UNLOCK4
    } seq_state_t;
endpackage

// File: rtl/strobe_sync.sv
// Synchronises the asynchronous active-low write strobe and produces
// one-cycle pulses at its falling and rising edges.
// Assumes the strobe stays in each level for more than SYNC_STAGES+1 clocks.
module strobe_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_n,
    output logic fall_pulse,
    output logic rise_pulse
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    // Shift the raw strobe through the synchroniser chain; idle level is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], strobe_n};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    // Compare the synchronised level with its previous value to find edges.
    always_comb begin
        fall_pulse = prev_q && !sync_q[SYNC_STAGES-1];
        rise_pulse = !prev_q && sync_q[SYNC_STAGES-1];
    end
endmodule

// File: rtl/bus_capture.sv
// Latches the write address at the strobe's falling edge and the data at its
// rising edge, then presents one completed write for a single cycle.
// Assumes address and data are stable while their edge is being detected.
module bus_capture
    import erase_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fall_pulse,
    input  logic              rise_pulse,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    output logic              ev_valid,
    output logic [ADDR_W-1:0] ev_addr,
    output logic [DATA_W-1:0] ev_data
);
    logic [ADDR_W-1:0] lat_addr;

    // Hold the address seen at the start of the write pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)          lat_addr <= '0;
        else if (fall_pulse) lat_addr <= bus_addr;
    end

    // Emit the completed write when the pulse ends, taking data at that moment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev_valid <= 1'b0;
            ev_addr  <= '0;
            ev_data  <= '0;
        end else begin
            ev_valid <= rise_pulse;
            if (rise_pulse) begin
                ev_addr <= lat_addr;
                ev_data <= bus_data;
            end
        end
    end

    // R4: the latched address equals the bus value at the falling edge.
    assert_addr_at_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(fall_pulse) |-> lat_addr == $past(bus_addr));

    // R5: the write's data equals the bus value at the rising edge.
    assert_data_at_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid |-> ev_data == $past(bus_data));
endmodule

// File: rtl/erase_seq_fsm.sv
// Walks the six-write erase sequence and raises a one-cycle request with the
// erase type and sector. Writes that break the sequence return it to idle.
// Assumes a busy engine must see no new request, so busy forces idle.
module erase_seq_fsm
    import erase_cmd_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                engine_busy,
    input  logic                ev_valid,
    input  logic [ADDR_W-1:0]   ev_addr,
    input  logic [DATA_W-1:0]   ev_data,
    output logic                erase_req,
    output logic                erase_chip,
    output logic [SECTOR_W-1:0] erase_sector
);
    seq_state_t          state_q;
    logic [OFFSET_W-1:0] ev_offset;
    logic [SECTOR_W-1:0] ev_sector;
    logic                hit_a;
    logic                hit_b;

    // Split the write address into in-sector offset and sector number and match unlock writes.
    always_comb begin
        ev_offset = ev_addr[OFFSET_W-1:0];
        ev_sector = ev_addr[ADDR_W-1 -: SECTOR_W];
        hit_a     = (ev_offset == UNLOCK_A_ADDR) && (ev_data == UNLOCK_A_DATA);
        hit_b     = (ev_offset == UNLOCK_B_ADDR) && (ev_data == UNLOCK_B_DATA);
    end

    // Advance on each matching write, fall back to idle on any mismatch or while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            erase_req    <= 1'b0;
            erase_chip   <= 1'b0;
            erase_sector <= '0;
        end else begin
            erase_req <= 1'b0;
            if (engine_busy) begin
                state_q <= ST_IDLE;
            end else if (ev_valid) begin
                unique case (state_q)
                    ST_IDLE:    state_q <= hit_a ? ST_UNLOCK1 : ST_IDLE;
                    ST_UNLOCK1: state_q <= hit_b ? ST_UNLOCK2 : ST_IDLE;
                    ST_UNLOCK2: state_q <= (ev_offset == UNLOCK_A_ADDR && ev_data == SETUP_CODE)
                                           ? ST_SETUP : ST_IDLE;
                    ST_SETUP:   state_q <= hit_a ? ST_UNLOCK3 : ST_IDLE;
                    ST_UNLOCK3: state_q <= hit_b ? ST_UNLOCK4 : ST_IDLE;
                    ST_UNLOCK4: begin
                        state_q <= ST_IDLE;
                        if (ev_offset == UNLOCK_A_ADDR && ev_data == CHIP_CODE) begin
                            erase_req    <= 1'b1;
                            erase_chip   <= 1'b1;
                            erase_sector <= '0;
                        end else if (ev_data == SECTOR_CODE) begin
                            erase_req    <= 1'b1;
                            erase_chip   <= 1'b0;
                            erase_sector <= ev_sector;
                        end
                    end
                    default:    state_q <= ST_IDLE;
                endcase
            end
        end
    end

    // R6: a request lasts a single cycle.
    assert_req_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |=> !erase_req);

    // R6: a request only follows a completed write.
    assert_req_after_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |-> $past(ev_valid));

    // R9: no request in the cycle after the engine reported busy.
    assert_no_req_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |-> !$past(engine_busy));

    // R2: a whole-device request comes from the chip code at the unlock address.
    assert_chip_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_req && erase_chip) |-> ($past(ev_data) == CHIP_CODE
                                       && $past(ev_offset) == UNLOCK_A_ADDR));

    // R3: a sector request carries the sector code and the final write's sector.
    assert_sector_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_req && !erase_chip) |-> ($past(ev_data) == SECTOR_CODE
                                        && erase_sector == $past(ev_sector)));
endmodule

// File: rtl/erase_cmd_decoder.sv
// Top of the erase command decoder: strobe synchroniser, write capture and
// sequence state machine in a chain. Assumes an asynchronous active-low
// write strobe and a busy flag from the erase engine in the clk domain.
module erase_cmd_decoder
    import erase_cmd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_data,
    input  logic                engine_busy,
    output logic                erase_req,
    output logic                erase_chip,
    output logic [SECTOR_W-1:0] erase_sector
);
    logic              fall_pulse;
    logic              rise_pulse;
    logic              ev_valid;
    logic [ADDR_W-1:0] ev_addr;
    logic [DATA_W-1:0] ev_data;

    strobe_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe_n   (we_n),
        .fall_pulse (fall_pulse),
        .rise_pulse (rise_pulse)
    );

    bus_capture u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .fall_pulse (fall_pulse),
        .rise_pulse (rise_pulse),
        .bus_addr   (bus_addr),
        .bus_data   (bus_data),
        .ev_valid   (ev_valid),
        .ev_addr    (ev_addr),
        .ev_data    (ev_data)
    );

    erase_seq_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .engine_busy  (engine_busy),
        .ev_valid     (ev_valid),
        .ev_addr      (ev_addr),
        .ev_data      (ev_data),
        .erase_req    (erase_req),
        .erase_chip   (erase_chip),
        .erase_sector (erase_sector)
    );
endmodule

// File: tb/test_erase_cmd_decoder.sv
module test_erase_cmd_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we_n = 1'b1;
    logic [20:0] bus_addr = '0;
    logic [7:0]  bus_data = '0;
    logic        engine_busy = 1'b0;
    logic        erase_req;
    logic        erase_chip;
    logic [3:0]  erase_sector;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    erase_cmd_decoder i_erase_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .we_n(we_n), .bus_addr(bus_addr),
        .bus_data(bus_data), .engine_busy(engine_busy), .erase_req(erase_req),
        .erase_chip(erase_chip), .erase_sector(erase_sector)
    );

    typedef struct packed {
        logic [20:0] addr;
        logic [7:0]  data;
        logic        req;     // a request is expected after this write
        logic        chip;
        logic [3:0]  sec;
        logic [3:0]  tag;     // requirement number for the message
    } vec_t;

    localparam int NV = 29;
    localparam vec_t VECS [NV] = '{
        // R2: whole-device erase
        '{21'h000555, 8'hAA, 1'b0, 1'b0, 4'd0, 4'd2},
        '{21'h0002AA, 8'h55, 1'b0, 1'b0, 4'd0, 4'd2},
        '{21'h000555, 8'h80, 1'b0, 1'b0, 4'd0, 4'd2},
        '{21'h000555, 8'hAA, 1'b0, 1'b0, 4'd0, 4'd2},
        '{21'h0002AA, 8'h55, 1'b0, 1'b0, 4'd0, 4'd2},
        '{21'h000555, 8'h10, 1'b1, 1'b1, 4'd0, 4'd2},
        // R3: sector erase, sector 1 (address 031234H); sector bits ignored on unlocks
        '{21'h0E0555, 8'hAA, 1'b0, 1'b0, 4'd0, 4'd3},
        '{21'h0002AA, 8'h55, 1'b0, 1'b0, 4'd0, 4'd3},
        '{21'h000555, 8'h80, 1'b0, 1'b0, 4'd0, 4'd3},
        '{21'h000555, 8'hAA, 1'b0, 1'b0, 4'd0, 4'd3},
        '{21'h1E02AA, 8'h55, 1'b0, 1'b0, 4'd0, 4'd3},
        '{21'h031234, 8'h30, 1'b1, 1'b0, 4'd1, 4'd3},
        // R7: sequence broken at write four, the rest gives nothing
        '{21'h000555, 8'hAA, 1'b0, 1'b0, 4'd0, 4'd7},
        '{21'h0002AA, 8'h55, 1'b0, 1'b0, 4'd0, 4'd7},
        '{21'h000555, 8'h80, 1'b0, 1'b0, 4'd0, 4'd7},
        '{21'h000555, 8'h55, 1'b0, 1'b0, 4'd0, 4'd7},
        '{21'h0002AA, 8'h55, 1'b0, 1'b0, 4'd0, 4'd7},
        '{21'h1FFFFF, 8'h30, 1'b0, 1'b0, 4'd0, 4'd7},
        // R8: wrong final code
        '{21'h000555, 8'hAA, 1'b0, 1'b0, 4'd0, 4'd8},
        '{21'h0002AA, 8'h55, 1'b0, 1'b0, 4'd0, 4'd8},
        '{21'h000555, 8'h80, 1'b0, 1'b0, 4'd0, 4'd8},
        '{21'h000555, 8'hAA, 1'b0, 1'b0, 4'd0, 4'd8},
        '{21'h0002AA, 8'h55, 1'b0, 1'b0, 4'd0, 4'd8},
        '{21'h000555, 8'h20, 1'b0, 1'b0, 4'd0, 4'd8},
        // R3 / R7: fresh sequence after the failures, top sector 15
        '{21'h000555, 8'hAA, 1'b0, 1'b0, 4'd0, 4'd3},
        '{21'h0002AA, 8'h55, 1'b0, 1'b0, 4'd0, 4'd3},
        '{21'h000555, 8'h80, 1'b0, 1'b0, 4'd0, 4'd3},
        '{21'h000555, 8'hAA, 1'b0, 1'b0, 4'd0, 4'd3},
        '{21'h0002AA, 8'h55, 1'b0, 1'b0, 4'd0, 4'd3}
    };

    task automatic check(input string what, input int tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // One bus write: address/data on the falling side, switched before the rising side.
    // Then watch 8 cycles, counting request cycles and keeping their type and sector.
    task automatic bus_write(input logic [20:0] a_fall, input logic [20:0] a_rise,
                             input logic [7:0] d_fall, input logic [7:0] d_rise,
                             output int pulses, output logic chip, output logic [3:0] sec);
        @(negedge clk);
        bus_addr = a_fall; bus_data = d_fall; we_n = 1'b0;
        repeat (4) @(negedge clk);
        bus_addr = a_rise; bus_data = d_rise;
        @(negedge clk);
        we_n = 1'b1;
        pulses = 0; chip = 1'b0; sec = '0;
        repeat (8) begin
            @(negedge clk);
            if (erase_req) begin
                pulses++; chip = erase_chip; sec = erase_sector;
            end
        end
    endtask

    task automatic simple_write(input logic [20:0] a, input logic [7:0] d, output int pulses);
        logic       c;
        logic [3:0] s;
        bus_write(a, a, d, d, pulses, c, s);
    endtask

    task automatic lead_in(input int count);
        int p;
        logic [20:0] la [5] = '{21'h555, 21'h2AA, 21'h555, 21'h555, 21'h2AA};
        logic [7:0]  ld [5] = '{8'hAA, 8'h55, 8'h80, 8'hAA, 8'h55};
        for (int k = 0; k < count; k++) begin
            simple_write(la[k], ld[k], p);
            check("no request during lead-in", 6, p, 0);   // R6
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        int p;
        logic c;
        logic [3:0] s;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset values
        check("req after reset", 1, erase_req, 0);
        check("chip after reset", 1, erase_chip, 0);
        check("sector after reset", 1, erase_sector, 0);

        // Table walk: R2, R3, R6, R7, R8
        for (int i = 0; i < NV; i++) begin
            bus_write(VECS[i].addr, VECS[i].addr, VECS[i].data, VECS[i].data, p, c, s);
            check($sformatf("vector %0d request cycles", i), VECS[i].tag, p, VECS[i].req ? 1 : 0);
            if (VECS[i].req) begin
                check($sformatf("vector %0d type", i), VECS[i].tag, c, VECS[i].chip);
                check($sformatf("vector %0d sector", i), VECS[i].tag, s, VECS[i].sec);
            end
        end
        // Final write of the last table sequence, sector 15 (1F0000H)
        simple_write(21'h1F0000, 8'h30, p);
        check("sector 15 request", 3, p, 1);   // R3
        check("sector 15 number", 3, erase_sector, 15);

        // R4: address taken at the falling edge, later change ignored
        lead_in(5);
        bus_write(21'h0A0000, 21'h120000, 8'h30, 8'h30, p, c, s);
        check("request with moved address", 4, p, 1);   // R4
        check("sector from falling-edge address", 4, s, 5);

        // R5: data taken at the rising edge
        lead_in(5);
        bus_write(21'h000555, 21'h000555, 8'h30, 8'h10, p, c, s);
        check("request with late data", 5, p, 1);       // R5
        check("type from rising-edge data", 5, c, 1);

        // R8: chip code away from the unlock address
        lead_in(5);
        simple_write(21'h000123, 8'h10, p);
        check("chip code at wrong address", 8, p, 0);   // R8

        // R9: full sequence while busy
        engine_busy = 1'b1;
        lead_in(5);
        simple_write(21'h000555, 8'h10, p);
        check("no request while busy", 9, p, 0);        // R9
        engine_busy = 1'b0;

        // R9: busy pulse in the middle discards progress
        lead_in(3);
        @(negedge clk); engine_busy = 1'b1;
        repeat (3) @(negedge clk); engine_busy = 1'b0;
        simple_write(21'h000555, 8'hAA, p);
        simple_write(21'h0002AA, 8'h55, p);
        simple_write(21'h040000, 8'h30, p);
        check("busy in mid-sequence discards it", 9, p, 0);   // R9

        // R1: reset in mid-sequence discards it
        lead_in(5);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        simple_write(21'h040000, 8'h30, p);
        check("reset discards partial sequence", 1, p, 0);    // R1

        // R7: decoder usable after all of the above
        lead_in(5);
        bus_write(21'h0E0000, 21'h0E0000, 8'h30, 8'h30, p, c, s);
        check("fresh sequence accepted", 7, p, 1);            // R7
        check("fresh sequence sector", 7, s, 7);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule